// File: doc/BRIEF.md
# Double-Buffered Register Bank with Timed Update

This block keeps a small bank of byte-wide control registers in two copies. A host writes single bytes into the staging copy at any time. The live copy keeps driving the datapath until an update event. The update copies the whole staging copy into the live copy on one clock edge, so the datapath never sees a set that is only half written.

An update event comes from one of three places:
- A host transfer command, which is honoured in either mode.
- A periodic internal timer. Its 32-bit period counts in steps of two clock cycles.
- An external update pin. The pin is synchronized with two flops and acts on its rising edge.

A source-select input picks timer mode or external mode. In external mode the timer is held idle. An `upd_done` flag is high during the cycle in which a new live set first appears.

Top module: `upd_reg_bank`

## Requirements
- R1: After reset both copies hold all zeros and `upd_done` is low.
- R2: A host write (`wr_en` high) stores `wr_data` into staging byte `wr_addr`. Byte k occupies live bits [8k+7:8k]. The live copy does not change until an update.
- R3: An update copies every staging byte into the live copy on a single clock edge. `upd_done` is high in the cycle after that edge and low otherwise.
- R4: A one-cycle `xfer_cmd` pulse causes an update on the next clock edge, whether `src_ext` is 0 or 1.
- R5: With `src_ext`=0 and `period`=P>0, updates occur every 2P clock cycles. The first update comes 2P cycles after the timer becomes enabled.
- R6: With `period`=0 the internal timer never causes an update.
- R7: With `src_ext`=1 the internal timer is disabled. A rising edge on `ext_upd` causes exactly one update on the third rising clock edge after the pin goes high, even if the pin stays high.
- R8: With `src_ext`=0 the `ext_upd` pin has no effect on the live copy.
- R9: If a host write and an update fall on the same edge, the live copy receives the staging value from before the write. The written byte still lands in the staging copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | $clog2(NREGS) | Staging byte index |
| wr_data | input | DW | Byte to write |
| xfer_cmd | input | 1 | Host transfer command pulse |
| src_ext | input | 1 | 0 = internal timer, 1 = external pin |
| ext_upd | input | 1 | Asynchronous external update pin |
| period | input | 32 | Timer period in units of two clocks; 0 disables the timer |
| active_q | output | NREGS*DW | Live register copy, byte k at bits [DW*k+DW-1:DW*k] |
| upd_done | output | 1 | High in the cycle a new live set appears |

## Verification
The bench builds the bank with NREGS=4 and DW=8. With these values every byte lane can be given a distinct value, and any lane that is copied wrongly or copied late shows up in the 32-bit live vector. Short periods of 1 and 3 bring the 2- and 6-cycle timer intervals within reach, so the exact firing edge can be counted directly. Holding the external pin high for many cycles, with the timer period still nonzero, exercises single-edge detection and timer disabling together.

// File: rtl/upd_reg_bank.sv
module upd_reg_bank #(
  parameter int NREGS = 8,
  parameter int DW    = 8,
  localparam int AW   = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic                xfer_cmd,
  input  logic                src_ext,
  input  logic                ext_upd,
  input  logic [31:0]         period,
  output logic [NREGS*DW-1:0] active_q,
  output logic                upd_done
);

  logic [NREGS-1:0][DW-1:0] hold, act;
  logic [2:0]  ext_sync;
  logic [32:0] tmr_cnt;
  logic        tmr_on, tmr_hit, ext_rise, upd_fire;

  assign tmr_on   = !src_ext && (period != 32'd0);
  assign tmr_hit  = tmr_on && (tmr_cnt >= ({period, 1'b0} - 33'd1));
  assign ext_rise = ext_sync[1] && !ext_sync[2];
  assign upd_fire = xfer_cmd || tmr_hit || (src_ext && ext_rise);
  assign active_q = act;

  always_ff @(posedge clk) begin
    if (!rst_n) ext_sync <= '0;
    else        ext_sync <= {ext_sync[1:0], ext_upd};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !tmr_on || tmr_hit) tmr_cnt <= '0;
    else                              tmr_cnt <= tmr_cnt + 33'd1;
  end

  for (genvar k = 0; k < NREGS; k++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold[k] <= '0;
        act[k]  <= '0;
      end else begin
        if (wr_en && (32'(wr_addr) == k)) hold[k] <= wr_data;
        if (upd_fire)                     act[k]  <= hold[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) upd_done <= 1'b0;
    else        upd_done <= upd_fire;
  end

  // R3
  copy_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |=> (active_q == $past(hold)));

  // R2
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_fire |=> $stable(active_q));

  // R6
  zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period == 32'd0 && !src_ext && !xfer_cmd) |-> !upd_fire);

  // R7
  ext_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);

  // R7
  tmr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ext |=> (tmr_cnt == 33'd0));

  // R1
  reset_done_chk: assert property (@(posedge clk)
    !rst_n |=> (!upd_done && active_q == '0));

endmodule

// File: tb/sim_upd_reg_bank.sv
`timescale 1ns/1ps
module sim_upd_reg_bank;
  localparam int N  = 4;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, xfer_cmd = 0, src_ext = 0, ext_upd = 0;
  logic [1:0]  wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic [31:0] period = 0;
  logic [N*DW-1:0] active_q;
  logic upd_done;

  int checks = 0, fails = 0;
  logic [N*DW-1:0] hmodel = '0;
  logic [N*DW-1:0] expq[$];
  string tag = "R1";

  always #2 clk = ~clk;

  upd_reg_bank #(.NREGS(N), .DW(DW)) u0 (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .xfer_cmd, .src_ext,
    .ext_upd, .period, .active_q, .upd_done);

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && upd_done) begin
    if (expq.size() == 0) chk({tag, " unexpected update"}, active_q, 64'hDEAD);
    else chk({tag, " copy"}, active_q, expq.pop_front());
  end

  task automatic hwrite(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a[1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    hmodel[a*8 +: 8] = d;
  endtask

  task automatic xfer();
    @(negedge clk);
    expq.push_back(hmodel);
    xfer_cmd = 1;
    @(negedge clk);
    xfer_cmd = 0;
  endtask

  task automatic count_to_upd(input string r, input int exp);
    int n = 0;
    while (n < 100) begin
      @(negedge clk); n++;
      if (upd_done) break;
    end
    chk(r, n, exp);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    chk("R1 live", active_q, 0);
    chk("R1 done", upd_done, 0);

    tag = "R2";
    hwrite(0, 8'h11); hwrite(1, 8'h22); hwrite(2, 8'h33); hwrite(3, 8'h44);
    repeat (5) @(negedge clk);
    chk("R2 live unchanged", active_q, 0);

    tag = "R3";
    xfer();
    chk("R3 live", active_q, 32'h44332211);
    @(negedge clk);
    chk("R3 done one cycle", upd_done, 0);

    tag = "R9";
    @(negedge clk);
    expq.push_back(hmodel);
    wr_en = 1; wr_addr = 1; wr_data = 8'hAA; xfer_cmd = 1;
    @(negedge clk);
    wr_en = 0; xfer_cmd = 0; hmodel[15:8] = 8'hAA;
    chk("R9 old value copied", active_q, 32'h44332211);
    xfer();
    chk("R9 write landed", active_q, 32'h4433AA11);

    tag = "R5";
    hwrite(3, 8'h5C);
    @(negedge clk);
    expq.push_back(hmodel); expq.push_back(hmodel);
    period = 3;
    count_to_upd("R5 first interval", 6);
    count_to_upd("R5 second interval", 6);
    period = 0;
    chk("R5 live", active_q, 32'h5C33AA11);

    tag = "R6";
    hwrite(0, 8'h77);
    repeat (40) @(negedge clk);
    chk("R6 no timer update", active_q, 32'h5C33AA11);

    tag = "R7";
    src_ext = 1; period = 1;
    repeat (20) @(negedge clk);
    chk("R7 timer disabled", active_q, 32'h5C33AA11);
    expq.push_back(hmodel);
    ext_upd = 1;
    count_to_upd("R7 latency", 3);
    chk("R7 live", active_q, 32'h5C33AA77);
    hwrite(2, 8'h99);
    repeat (10) @(negedge clk);
    chk("R7 single update", active_q, 32'h5C33AA77);
    ext_upd = 0;

    tag = "R4";
    xfer();
    chk("R4 xfer in ext mode", active_q, 32'h5C99AA77);

    tag = "R8";
    src_ext = 0; period = 0;
    hwrite(1, 8'h01);
    ext_upd = 1; repeat (6) @(negedge clk);
    ext_upd = 0; repeat (6) @(negedge clk);
    chk("R8 pin ignored", active_q, 32'h5C99AA77);

    tag = "R4";
    xfer();
    chk("R4 xfer in internal mode", active_q, 32'h5C990177);

    repeat (3) @(negedge clk);
    chk("R3 queue drained", expq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule